// File: doc/BRIEF.md
# External Bus Access Sequencer

This block runs read and write cycles on an asynchronous external memory bus for one internal master. The master hands over one access at a time on a valid/ready channel: address, write data, byte enables, a write flag and a chip select index. The sequencer then drives the external address, the active-low chip select, output enable, write strobe and byte enables, and the data-bus drive enable. It returns read data with a one-cycle response pulse.

Each chip select has two 3-bit settings, written through a plain register write port. The wait count stretches every access on that select by one clock per wait state. The float count sets the bus turnaround time that must pass before the next access may start.

The float time is taken from the chip select of the access that has just finished. It counts down on its own, so idle time on the bus already covers it. The write strobe comes from a falling-edge register and rises half a clock before the access ends. Address, data and chip select therefore stay valid past the strobe's rising edge.

Back-pressure: `req_ready` is high only while no access is running and no float time is left. A transfer happens on a rising edge where `req_valid` and `req_ready` are both high. The master must hold a request and its fields stable until that edge. There is no back-pressure on the response: `rsp_valid` is a single-cycle pulse that the master must take when it appears.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, every `bus_cs_n` bit is 1, `bus_oe_n`, `bus_we_n` and both `bus_be_n` bits are 1, and `bus_doe` is 0. Every chip select's wait and float settings are 0.
- R2: A request is taken on a rising edge with `req_valid` and `req_ready` both 1. From the next cycle `req_ready` stays 0 until the access and its float time are over.
- R3: An access on chip select k with wait setting W lasts exactly 1+W cycles, starting the cycle after acceptance. During those cycles `bus_cs_n` has only bit k low and `bus_addr` holds the request address. A read also holds `bus_oe_n` low for the same cycles; a write keeps `bus_oe_n` high.
- R4: A read's data is taken from `bus_din` on the last rising edge of the access. In the next cycle `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` carries that data. All chip selects are then high again.
- R5: During a write, `bus_doe` is 1 and `bus_dout` holds the write data for all 1+W cycles. `bus_we_n` is low from the start of the first cycle and goes high at the falling clock edge in the middle of the last cycle. `bus_we_n` and `bus_oe_n` are never low together.
- R6: After an access on a chip select with float setting F, `req_ready` is 0 in the response cycle and the F-1 cycles after it, and becomes 1 F cycles after the response cycle. With F=0 it is already 1 in the response cycle.
- R7: Float time runs down while the bus is idle. A request presented after idle time shorter than F waits only for the rest of the float time. A request presented after at least F cycles is accepted at once.
- R8: The float time comes from the chip select of the access that has just completed, not from the chip select of the waiting request.
- R9: A write with `cfg_we`=1 stores `cfg_wait` and `cfg_float` for select `cfg_sel`. Accesses accepted afterwards on that select use the new values.
- R10: During an access, `bus_be_n` is the bitwise inverse of the request's `req_be` (bit 0 is the low byte lane). Outside accesses both bits are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge for the sequencer, falling edge for the strobe timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for the per-select settings |
| cfg_sel | input | 2 | Chip select whose settings are written |
| cfg_wait | input | 3 | Wait state count, 0 to 7 |
| cfg_float | input | 3 | Float turnaround count, 0 to 7 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sel | input | 2 | Chip select index of the request |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, active high |
| rsp_valid | output | 1 | One-cycle pulse when an access completes |
| rsp_rdata | output | 16 | Data from the last read |
| bus_addr | output | 16 | External address |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable for reads |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_be_n | output | 2 | Active-low byte lane enables |
| bus_dout | output | 16 | Data driven on writes |
| bus_doe | output | 1 | Data bus drive enable |
| bus_din | input | 16 | Data returned by the external device |

## Verification
Bus pins change one rising edge after the accepting edge and stay for 1+W cycles. `rsp_valid` and read data follow one edge after the last active cycle. `req_ready` comes back F edges after the response cycle. The write strobe alone moves on the falling edge. The bench drives and samples 2 ns after each rising edge, steps exactly one edge per expected cycle, and looks at the strobe a second time 2 ns after the falling edge of each write cycle. This shows the early rise of the strobe. Float behaviour is measured by counting the cycles with `req_ready` low from the response cycle onward, and the counts are compared with a model of the per-select settings kept in the bench.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/ebs_cfg_bank.sv
module ebs_cfg_bank #(
  parameter int NUM_SEL = 4,
  parameter int CNT_W   = 3,
  localparam int SEL_W  = $clog2(NUM_SEL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_wait,
  input  logic [CNT_W-1:0] wr_float,
  input  logic [SEL_W-1:0] wait_sel,
  output logic [CNT_W-1:0] wait_val,
  input  logic [SEL_W-1:0] float_sel,
  output logic [CNT_W-1:0] float_val
);

  logic [CNT_W-1:0] wait_q  [NUM_SEL];
  logic [CNT_W-1:0] float_q [NUM_SEL];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wait_q[i]  <= '0;
        float_q[i] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(i))) begin
        wait_q[i]  <= wr_wait;
        float_q[i] <= wr_float;
      end
    end
  end

  assign wait_val  = wait_q[wait_sel];
  assign float_val = float_q[float_sel];

endmodule

// File: rtl/ebs_float_timer.sv
module ebs_float_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy = (left_q != '0);

  // the counter only moves down or reloads; it never wraps from zero
  AST_FLOAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && left_q == '0) |=> (left_q == '0)); // R7

endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_active,
  input  logic last_cycle,
  output logic we_n
);

  logic late_half_q;

  // falling-edge register: marks the second half of the last write cycle
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_half_q <= 1'b0;
    end else begin
      late_half_q <= wr_active && last_cycle;
    end
  end

  assign we_n = !(wr_active && !late_half_q);

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int NUM_SEL = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 3,
  localparam int SEL_W  = $clog2(NUM_SEL),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CNT_W-1:0]  cfg_wait,
  input  logic [CNT_W-1:0]  cfg_float,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_SEL-1:0] bus_cs_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [BE_W-1:0]   bus_be_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  import ebs_pkg::*;

  typedef struct packed {
    logic              write;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [BE_W-1:0]   be;
  } access_t;

  seq_state_e       state_q;
  access_t          cur_q;
  logic [CNT_W-1:0] wait_left_q;
  logic             rsp_valid_q;
  logic [DATA_W-1:0] rdata_q;

  logic [CNT_W-1:0] sel_wait;
  logic [CNT_W-1:0] done_float;
  logic             float_busy;
  logic             accept;
  logic             running;
  logic             last_cycle;

  ebs_cfg_bank #(.NUM_SEL(NUM_SEL), .CNT_W(CNT_W)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_sel    (cfg_sel),
    .wr_wait   (cfg_wait),
    .wr_float  (cfg_float),
    .wait_sel  (req_sel),
    .wait_val  (sel_wait),
    .float_sel (cur_q.sel),
    .float_val (done_float)
  );

  assign running    = (state_q == SEQ_RUN);
  assign last_cycle = running && (wait_left_q == '0);
  assign req_ready  = (state_q == SEQ_IDLE) && !float_busy;
  assign accept     = req_valid && req_ready;

  ebs_float_timer #(.CNT_W(CNT_W)) i_float (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (last_cycle),
    .load_val (done_float),
    .busy     (float_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      cur_q       <= '0;
      wait_left_q <= '0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        state_q     <= SEQ_RUN;
        cur_q       <= '{write: req_write, sel: req_sel, addr: req_addr,
                         wdata: req_wdata, be: req_be};
        wait_left_q <= sel_wait;
      end else if (running) begin
        if (wait_left_q == '0) begin
          state_q     <= SEQ_IDLE;
          rsp_valid_q <= 1'b1;
          if (!cur_q.write) rdata_q <= bus_din;
        end else begin
          wait_left_q <= wait_left_q - 1'b1;
        end
      end
    end
  end

  ebs_strobe_gen i_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_active  (running && cur_q.write),
    .last_cycle (last_cycle),
    .we_n       (bus_we_n)
  );

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_cs
    assign bus_cs_n[i] = !(running && (cur_q.sel == SEL_W'(i)));
  end

  assign bus_addr  = cur_q.addr;
  assign bus_dout  = cur_q.wdata;
  assign bus_oe_n  = !(running && !cur_q.write);
  assign bus_doe   = running && cur_q.write;
  assign bus_be_n  = running ? ~cur_q.be : '1;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !req_ready); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !last_cycle) |=> ($stable(bus_addr) && $stable(bus_cs_n))); // R3
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_RSP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> &bus_cs_n); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n)); // R5
  AST_FLOAT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    float_busy |-> !req_ready); // R6
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)); // R3
  AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (&bus_cs_n) |-> (&bus_be_n)); // R10

endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_wait = '0;
  logic [2:0]  cfg_float = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_sel = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] bus_addr;
  logic [3:0]  bus_cs_n;
  logic        bus_oe_n;
  logic        bus_we_n;
  logic [1:0]  bus_be_n;
  logic [15:0] bus_dout;
  logic        bus_doe;
  logic [15:0] bus_din;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  int m_wait [4];
  int m_float [4];

  always #4 clk = ~clk;

  // external device model: read data is a fixed function of the address
  assign bus_din = bus_oe_n ? 16'h0000 : (bus_addr ^ 16'h5A3C);

  ext_bus_seq i_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wait(cfg_wait), .cfg_float(cfg_float), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_sel(req_sel),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_be_n(bus_be_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din)
  );

  // vector: {sel[36:35], write[34], be[33:32], addr[31:16], wdata[15:0]}
  localparam logic [36:0] VEC [8] = '{
    {2'd0, 1'b0, 2'b11, 16'h0010, 16'h0000},
    {2'd1, 1'b1, 2'b01, 16'h0124, 16'hBEEF},
    {2'd2, 1'b0, 2'b11, 16'h2200, 16'h0000},
    {2'd3, 1'b1, 2'b10, 16'h3306, 16'h1234},
    {2'd0, 1'b1, 2'b11, 16'h0008, 16'h5555},
    {2'd1, 1'b0, 2'b10, 16'h1AAA, 16'h0000},
    {2'd3, 1'b0, 2'b11, 16'h3FF0, 16'h0000},
    {2'd2, 1'b1, 2'b11, 16'h2468, 16'hA0A0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int sel, input int w, input int f);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wait = 3'(w); cfg_float = 3'(f);
    @(posedge clk); #2;
    cfg_we = 1'b0;
    m_wait[sel] = w; m_float[sel] = f;
  endtask

  // runs one access; returns in the response cycle (+2 ns) unless measure
  task automatic run_access(input int sel, input bit wr, input logic [1:0] be,
                            input logic [15:0] addr, input logic [15:0] wd,
                            input bit measure, input string note);
    int w = m_wait[sel];
    int n;
    logic [3:0] cs_exp = ~(4'b0001 << sel);
    while (!req_ready) begin @(posedge clk); #2; end
    req_valid = 1'b1; req_sel = 2'(sel); req_write = wr; req_be = be;
    req_addr = addr; req_wdata = wd;
    @(posedge clk); #2;
    req_valid = 1'b0;
    check(req_ready == 1'b0, {"R2 ready low while busy ", note}, 32'(req_ready), 0);
    for (int k = 0; k <= w; k++) begin
      check(bus_cs_n == cs_exp && bus_addr == addr,
            {"R3 select/address held ", note}, {bus_cs_n, bus_addr}, {cs_exp, addr});
      check(bus_oe_n == wr, {"R3 output enable ", note}, 32'(bus_oe_n), 32'(wr));
      check(bus_be_n == ~be, {"R10 lane enables ", note}, 32'(bus_be_n), 32'(~be));
      if (wr) begin
        check(bus_doe == 1'b1 && bus_dout == wd, {"R5 write data driven ", note},
              {bus_doe, bus_dout}, {1'b1, wd});
        check(bus_we_n == 1'b0, {"R5 strobe low first half ", note}, 32'(bus_we_n), 0);
        #4;
        check(bus_we_n == (k == w), {"R5 strobe second half ", note},
              32'(bus_we_n), 32'(k == w));
        @(posedge clk); #2;
      end else begin
        check(bus_doe == 1'b0, {"R3 no drive on read ", note}, 32'(bus_doe), 0);
        @(posedge clk); #2;
      end
    end
    check(rsp_valid == 1'b1 && bus_cs_n == 4'hF && bus_be_n == 2'b11,
          {"R4 response and bus release ", note}, {rsp_valid, bus_cs_n, bus_be_n},
          {1'b1, 4'hF, 2'b11});
    if (!wr)
      check(rsp_rdata == (addr ^ 16'h5A3C), {"R4 read data ", note},
            32'(rsp_rdata), 32'(addr ^ 16'h5A3C));
    if (measure) begin
      n = 0;
      while (!req_ready && n < 20) begin n++; @(posedge clk); #2; end
      check(n == m_float[sel], {"R6 R8 float cycles ", note}, 32'(n), 32'(m_float[sel]));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 4; i++) begin m_wait[i] = 0; m_float[i] = 0; end
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state while reset is held and just after release
    check(req_ready && !rsp_valid && bus_cs_n == 4'hF && bus_oe_n && bus_we_n
          && bus_be_n == 2'b11 && !bus_doe, "R1 reset outputs",
          {req_ready, rsp_valid, bus_cs_n, bus_oe_n, bus_we_n, bus_be_n, bus_doe},
          {1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 2'b11, 1'b0});
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1: default settings give a one-cycle access and no float
    run_access(0, 1'b0, 2'b11, 16'h0042, 16'h0, 1'b1, "R1 defaults");

    set_cfg(0, 0, 0);
    set_cfg(1, 2, 3);
    set_cfg(2, 7, 7);
    set_cfg(3, 1, 1);

    for (int v = 0; v < 8; v++) begin
      run_access(int'(VEC[v][36:35]), VEC[v][34], VEC[v][33:32], VEC[v][31:16],
                 VEC[v][15:0], 1'b1, $sformatf("vec%0d", v));
    end

    // R8: float from completed select (7) while a select-0 request waits
    run_access(2, 1'b0, 2'b11, 16'h2002, 16'h0, 1'b0, "R8 long float");
    req_valid = 1'b1; req_sel = 2'd0; req_write = 1'b0; req_be = 2'b11;
    req_addr = 16'h0004;
    n = 0;
    while (!req_ready && n < 20) begin n++; @(posedge clk); #2; end
    check(n == 7, "R8 waiting request held for completed select float",
          32'(n), 32'd7);
    req_valid = 1'b0;
    run_access(0, 1'b0, 2'b11, 16'h0004, 16'h0, 1'b1, "R8 follow-up");

    // R7: idle cycles count toward the float time
    run_access(2, 1'b1, 2'b01, 16'h2100, 16'h7E7E, 1'b0, "R7 partial");
    repeat (3) @(posedge clk); #0;
    n = 0;
    while (!req_ready && n < 20) begin n++; @(posedge clk); #2; end
    check(n == 4, "R7 remaining float after idle", 32'(n), 32'd4);
    run_access(2, 1'b0, 2'b11, 16'h2104, 16'h0, 1'b0, "R7 full idle");
    repeat (8) @(posedge clk);
    #2;
    check(req_ready == 1'b1, "R7 no delay after long idle", 32'(req_ready), 1);

    // R9: reconfigure select 1 and check new timing
    set_cfg(1, 5, 2);
    run_access(1, 1'b0, 2'b11, 16'h1230, 16'h0, 1'b1, "R9 new read timing");
    run_access(1, 1'b1, 2'b10, 16'h1232, 16'hC3C3, 1'b1, "R9 new write timing");
    set_cfg(3, 0, 0);
    run_access(3, 1'b1, 2'b11, 16'h3000, 16'h9999, 1'b1, "R9 zero wait write");

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule